// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This combinational block decides where a 32-bit fixed-format RISC core fetches next. Each cycle the decode stage presents the current program counter, a flow-class code, the 16-bit branch displacement field, the 26-bit jump field and the two source register values. The block returns the next PC, a flag saying whether control flow left the sequential path, and a link request with its value for the call-type classes.

Two-register branches compare for equality or inequality. Single-register branches compare against zero as a two's complement number. Two of the zero-compare branches also link. Direct jumps replace the low 28 bits of the incremented PC and keep its top four bits. Register jumps take the whole target from the first source register. The block has no fetch logic, no delay slot handling and no exception vectors.

Top module: `npc_unit`

## Requirements
- R1: The class code `kind_i` selects the behaviour: 0 sequential, 1 branch-if-equal, 2 branch-if-not-equal, 3 branch if rs <= 0, 4 branch if rs > 0, 5 branch if rs < 0, 6 branch if rs >= 0, 7 branch if rs < 0 with link, 8 branch if rs >= 0 with link, 9 direct jump, 10 direct jump with link, 11 register jump. When nothing is taken, `next_pc_o` equals `pc_i + 4` and `taken_o` is 0.
- R2: A taken branch goes to `pc_i + 4` plus the sign-extended 16-bit `offset_i` times 4. Negative displacements go backwards.
- R3: Class 1 is taken exactly when `rs_val_i == rt_val_i`, and class 2 exactly when they differ.
- R4: Classes 3 to 8 treat `rs_val_i` as two's complement and compare it against zero. The sign bit and an all-zero test decide each condition, and `rt_val_i` has no effect.
- R5: Classes 9 and 10 are always taken. Their target is bits 31:28 of `pc_i + 4`, then `jfield_i`, then two zero bits.
- R6: Class 10 raises `link_req_o` with `link_val_o = pc_i + 4`.
- R7: Class 11 is always taken, and `next_pc_o` equals `rs_val_i`.
- R8: Classes 7 and 8 raise `link_req_o` with `link_val_o = pc_i + 4` whether or not their condition holds.
- R9: `link_req_o` is 0 for every class other than 7, 8 and 10. Codes 12 to 15 behave as sequential.
- R10: All PC arithmetic wraps modulo 2^32. A PC of 0xFFFFFFFC falls through to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Current program counter |
| kind_i | input | 4 | Decoded flow class code |
| offset_i | input | 16 | Branch displacement in words |
| jfield_i | input | 26 | Direct jump word index within the region |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | Control flow leaves the sequential path |
| link_req_o | output | 1 | Request to write the return address to register 31 |
| link_val_o | output | 32 | Return address to write |

## Verification
Random register values almost never hit the conditions that matter. Two random values rarely match, and zero or the sign boundary rarely shows up, so the generator draws `rt_val_i` as a copy of `rs_val_i` part of the time and draws `rs_val_i` from 0, -1 and the extreme values part of the time. The hardest case is a linking branch whose condition fails, where the link must still be raised while the PC falls through. A second hard case is a direct jump from the last word of a 256 MB region, where the region bits must come from the incremented PC. Both are applied as directed vectors, and the PC wrap at the top of the address space is also directed.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN    = 32;
    localparam int OFF_W   = 16;
    localparam int JF_W    = 26;
    localparam int KIND_W  = 4;
    localparam int SCALE   = 2;
    localparam int RGN_W   = XLEN - JF_W - SCALE;
    localparam int STEP    = 4;

    typedef enum logic [KIND_W-1:0] {
        K_SEQ    = 4'd0,
        K_BEQ    = 4'd1,
        K_BNE    = 4'd2,
        K_BLEZ   = 4'd3,
        K_BGTZ   = 4'd4,
        K_BLTZ   = 4'd5,
        K_BGEZ   = 4'd6,
        K_BLTZL  = 4'd7,
        K_BGEZL  = 4'd8,
        K_JDIR   = 4'd9,
        K_JLINK  = 4'd10,
        K_JREG   = 4'd11
    } flow_kind_e;

    typedef struct packed {
        logic equal;
        logic is_zero;
        logic is_neg;
    } cmp_flags_t;

    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_REL    = 2'd1,
        SEL_REGION = 2'd2,
        SEL_REG    = 2'd3
    } tgt_sel_e;

    function automatic logic kind_links(input flow_kind_e k);
        return (k == K_BLTZL) || (k == K_BGEZL) || (k == K_JLINK);
    endfunction

    function automatic logic kind_is_branch(input flow_kind_e k);
        return (k >= K_BEQ) && (k <= K_BGEZL);
    endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int W      = XLEN,
    parameter int KW     = KIND_W
) (
    input  logic [KW-1:0] kind_i,
    input  logic [W-1:0]  rs_val_i,
    input  logic [W-1:0]  rt_val_i,
    output logic          cond_ok_o
);

    cmp_flags_t flags;
    flow_kind_e kind;

    always_comb begin
        flags.equal   = (rs_val_i == rt_val_i);
        flags.is_zero = ~|rs_val_i;
        flags.is_neg  = rs_val_i[W-1];
    end

    always_comb begin
        kind = flow_kind_e'(kind_i);
        unique case (kind)
            K_BEQ:            cond_ok_o = flags.equal;
            K_BNE:            cond_ok_o = ~flags.equal;
            K_BLEZ:           cond_ok_o = flags.is_neg | flags.is_zero;
            K_BGTZ:           cond_ok_o = ~flags.is_neg & ~flags.is_zero;
            K_BLTZ, K_BLTZL:  cond_ok_o = flags.is_neg;
            K_BGEZ, K_BGEZL:  cond_ok_o = ~flags.is_neg;
            default:          cond_ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
#(
    parameter int W   = XLEN,
    parameter int OW  = OFF_W,
    parameter int JW  = JF_W,
    parameter int SC  = SCALE
) (
    input  logic [W-1:0]  pc_i,
    input  logic [OW-1:0] offset_i,
    input  logic [JW-1:0] jfield_i,
    output logic [W-1:0]  seq_o,
    output logic [W-1:0]  rel_o,
    output logic [W-1:0]  region_o
);

    localparam int EXT_W = W - OW - SC;
    localparam int RW    = W - JW - SC;

    logic [W-1:0] disp;

    always_comb begin
        seq_o    = pc_i + W'(STEP);
        disp     = {{EXT_W{offset_i[OW-1]}}, offset_i, {SC{1'b0}}};
        rel_o    = seq_o + disp;
        region_o = {seq_o[W-1 -: RW], jfield_i, {SC{1'b0}}};
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int KW = KIND_W
) (
    input  logic [KW-1:0] kind_i,
    input  logic          cond_ok_i,
    input  logic [W-1:0]  seq_i,
    input  logic [W-1:0]  rel_i,
    input  logic [W-1:0]  region_i,
    input  logic [W-1:0]  reg_tgt_i,
    output logic [W-1:0]  next_pc_o,
    output logic          taken_o,
    output logic          link_req_o,
    output logic [W-1:0]  link_val_o
);

    flow_kind_e kind;
    tgt_sel_e   sel;

    always_comb begin
        kind = flow_kind_e'(kind_i);
        if (kind == K_JDIR || kind == K_JLINK)
            sel = SEL_REGION;
        else if (kind == K_JREG)
            sel = SEL_REG;
        else if (kind_is_branch(kind) && cond_ok_i)
            sel = SEL_REL;
        else
            sel = SEL_SEQ;
    end

    always_comb begin
        unique case (sel)
            SEL_REL:    next_pc_o = rel_i;
            SEL_REGION: next_pc_o = region_i;
            SEL_REG:    next_pc_o = reg_tgt_i;
            default:    next_pc_o = seq_i;
        endcase
        taken_o    = (sel != SEL_SEQ);
        link_req_o = kind_links(kind);
        link_val_o = seq_i;
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int OW = OFF_W,
    parameter int JW = JF_W,
    parameter int KW = KIND_W
) (
    input  logic [W-1:0]  pc_i,
    input  logic [KW-1:0] kind_i,
    input  logic [OW-1:0] offset_i,
    input  logic [JW-1:0] jfield_i,
    input  logic [W-1:0]  rs_val_i,
    input  logic [W-1:0]  rt_val_i,
    output logic [W-1:0]  next_pc_o,
    output logic          taken_o,
    output logic          link_req_o,
    output logic [W-1:0]  link_val_o
);

    logic         cond_ok;
    logic [W-1:0] seq_pc;
    logic [W-1:0] rel_pc;
    logic [W-1:0] region_pc;

    npc_cond_eval #(.W(W), .KW(KW)) u_cond (
        .kind_i    (kind_i),
        .rs_val_i  (rs_val_i),
        .rt_val_i  (rt_val_i),
        .cond_ok_o (cond_ok)
    );

    npc_target_gen #(.W(W), .OW(OW), .JW(JW), .SC(SCALE)) u_tgt (
        .pc_i     (pc_i),
        .offset_i (offset_i),
        .jfield_i (jfield_i),
        .seq_o    (seq_pc),
        .rel_o    (rel_pc),
        .region_o (region_pc)
    );

    npc_select #(.W(W), .KW(KW)) u_sel (
        .kind_i     (kind_i),
        .cond_ok_i  (cond_ok),
        .seq_i      (seq_pc),
        .rel_i      (rel_pc),
        .region_i   (region_pc),
        .reg_tgt_i  (rs_val_i),
        .next_pc_o  (next_pc_o),
        .taken_o    (taken_o),
        .link_req_o (link_req_o),
        .link_val_o (link_val_o)
    );

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
(
    input logic [XLEN-1:0]   pc_i,
    input logic [KIND_W-1:0] kind_i,
    input logic [OFF_W-1:0]  offset_i,
    input logic [JF_W-1:0]   jfield_i,
    input logic [XLEN-1:0]   rs_val_i,
    input logic [XLEN-1:0]   rt_val_i,
    input logic [XLEN-1:0]   next_pc_o,
    input logic              taken_o,
    input logic              link_req_o,
    input logic [XLEN-1:0]   link_val_o
);

    logic [XLEN-1:0] pc_plus;
    logic            is_dir_jump;
    logic            unused_ok;

    always_comb begin
        pc_plus     = pc_i + 32'd4;
        is_dir_jump = (kind_i == 4'd9) || (kind_i == 4'd10);
        unused_ok   = ^{offset_i, rt_val_i};
    end

    always_comb begin
        if (!taken_o)
            assert_fallthrough_R1: assert (next_pc_o == pc_plus);
        if (is_dir_jump)
            assert_region_keep_R5: assert (taken_o && next_pc_o[1:0] == 2'b00
                                            && next_pc_o[31:28] == pc_plus[31:28]
                                            && next_pc_o[27:2] == jfield_i);
        if (kind_i == 4'd11)
            assert_reg_jump_R7: assert (taken_o && next_pc_o == rs_val_i);
        if (link_req_o)
            assert_link_value_R8: assert (link_val_o == pc_plus);
        if (link_req_o)
            assert_link_kinds_R9: assert (kind_i == 4'd7 || kind_i == 4'd8 || kind_i == 4'd10);
        if (kind_i >= 4'd12)
            assert_unknown_quiet_R9: assert (!taken_o && !link_req_o && (unused_ok | !unused_ok));
    end

endmodule

bind npc_unit npc_unit_chk chk (.*);

// File: tb/npc_unit_test.sv
module npc_unit_test;

    logic        clk = 1'b0;
    logic [31:0] pc_i;
    logic [3:0]  kind_i;
    logic [15:0] offset_i;
    logic [25:0] jfield_i;
    logic [31:0] rs_val_i;
    logic [31:0] rt_val_i;
    logic [31:0] next_pc_o;
    logic        taken_o;
    logic        link_req_o;
    logic [31:0] link_val_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    npc_unit uut (
        .pc_i       (pc_i),
        .kind_i     (kind_i),
        .offset_i   (offset_i),
        .jfield_i   (jfield_i),
        .rs_val_i   (rs_val_i),
        .rt_val_i   (rt_val_i),
        .next_pc_o  (next_pc_o),
        .taken_o    (taken_o),
        .link_req_o (link_req_o),
        .link_val_o (link_val_o)
    );

    function automatic string tag_of(input logic [3:0] k);
        case (k)
            4'd0:              return "R1";
            4'd1, 4'd2:        return "R3";
            4'd3, 4'd4,
            4'd5, 4'd6:        return "R4";
            4'd7, 4'd8:        return "R8";
            4'd9:              return "R5";
            4'd10:             return "R6";
            4'd11:             return "R7";
            default:           return "R9";
        endcase
    endfunction

    function automatic void ref_model(
        input  logic [3:0]  k,
        input  logic [31:0] pc,
        input  logic [15:0] off,
        input  logic [25:0] jf,
        input  logic [31:0] rs,
        input  logic [31:0] rt,
        output logic [31:0] e_next,
        output logic        e_taken,
        output logic        e_link,
        output logic [31:0] e_lval
    );
        logic [31:0] pc4;
        logic [31:0] btgt;
        logic        hit;
        int signed   srs;
        int signed   soff;
        pc4  = pc + 32'd4;
        soff = int'($signed(off));
        btgt = pc4 + 32'(soff * 4);
        srs  = int'($signed(rs));
        hit  = 1'b0;
        case (k)
            4'd1: hit = (rs == rt);
            4'd2: hit = (rs != rt);
            4'd3: hit = (srs <= 0);
            4'd4: hit = (srs > 0);
            4'd5, 4'd7: hit = (srs < 0);
            4'd6, 4'd8: hit = (srs >= 0);
            default: hit = 1'b0;
        endcase
        e_lval = pc4;
        e_link = (k == 4'd7) || (k == 4'd8) || (k == 4'd10);
        if (k == 4'd9 || k == 4'd10) begin
            e_next  = {pc4[31:28], jf, 2'b00};
            e_taken = 1'b1;
        end else if (k == 4'd11) begin
            e_next  = rs;
            e_taken = 1'b1;
        end else if (hit) begin
            e_next  = btgt;
            e_taken = 1'b1;
        end else begin
            e_next  = pc4;
            e_taken = 1'b0;
        end
    endfunction

    task automatic apply(input logic [3:0] k, input logic [31:0] pc, input logic [15:0] off,
                         input logic [25:0] jf, input logic [31:0] rs, input logic [31:0] rt,
                         input string tag);
        logic [31:0] e_next;
        logic [31:0] e_lval;
        logic        e_taken;
        logic        e_link;
        @(negedge clk);
        kind_i = k; pc_i = pc; offset_i = off; jfield_i = jf; rs_val_i = rs; rt_val_i = rt;
        #2;
        ref_model(k, pc, off, jf, rs, rt, e_next, e_taken, e_link, e_lval);
        n_checks++;
        if (next_pc_o !== e_next || taken_o !== e_taken || link_req_o !== e_link
            || (e_link && link_val_o !== e_lval)) begin
            n_fail++;
            $display("FAIL %s kind=%0d: got next=%h taken=%b link=%b lval=%h, expected next=%h taken=%b link=%b lval=%h",
                     tag, k, next_pc_o, taken_o, link_req_o, link_val_o,
                     e_next, e_taken, e_link, e_lval);
        end
    endtask

    initial begin
        kind_i = 4'd0; pc_i = 32'h0000_1000; offset_i = '0; jfield_i = '0;
        rs_val_i = '0; rt_val_i = '0;
        void'($urandom(32'd20240611));

        // R1: idle code at start falls through
        apply(4'd0, 32'h0000_1000, 16'h0010, 26'h123, 32'd5, 32'd5, "R1");
        // R2: forward and backward displacement on equal branch
        apply(4'd1, 32'h0040_0000, 16'h0003, 26'h0, 32'd7, 32'd7, "R2");
        apply(4'd1, 32'h0040_0100, 16'hFFFE, 26'h0, 32'd7, 32'd7, "R2");
        apply(4'd2, 32'h0040_0100, 16'h8000, 26'h0, 32'd1, 32'd2, "R2");
        // R3: equality outcomes
        apply(4'd1, 32'h0000_2000, 16'h0004, 26'h0, 32'd1, 32'd2, "R3");
        apply(4'd2, 32'h0000_2000, 16'h0004, 26'h0, 32'd9, 32'd9, "R3");
        // R4: zero-compare edges, rt ignored
        apply(4'd3, 32'h0000_3000, 16'h0008, 26'h0, 32'd0, 32'hFFFF_FFFF, "R4");
        apply(4'd4, 32'h0000_3000, 16'h0008, 26'h0, 32'd0, 32'd1, "R4");
        apply(4'd4, 32'h0000_3000, 16'h0008, 26'h0, 32'h7FFF_FFFF, 32'd0, "R4");
        apply(4'd5, 32'h0000_3000, 16'h0008, 26'h0, 32'h8000_0000, 32'd0, "R4");
        apply(4'd6, 32'h0000_3000, 16'h0008, 26'h0, 32'hFFFF_FFFF, 32'd0, "R4");
        apply(4'd6, 32'h0000_3000, 16'h0008, 26'h0, 32'd0, 32'hFFFF_FFFF, "R4");
        // R5: region bits come from pc+4 at a region edge
        apply(4'd9, 32'h0FFF_FFFC, 16'h0, 26'h2AA_AAAA, 32'd0, 32'd0, "R5");
        apply(4'd9, 32'hA000_0000, 16'h0, 26'h3FF_FFFF, 32'd0, 32'd0, "R5");
        // R6: call
        apply(4'd10, 32'h1234_5678, 16'h0, 26'h000_0040, 32'd0, 32'd0, "R6");
        // R7: register jump
        apply(4'd11, 32'h0000_4000, 16'h0, 26'h0, 32'hDEAD_BEE0, 32'd0, "R7");
        // R8: linking branches, both outcomes
        apply(4'd7, 32'h0000_5000, 16'h0010, 26'h0, 32'd3, 32'd0, "R8");
        apply(4'd7, 32'h0000_5000, 16'h0010, 26'h0, 32'hFFFF_FFF0, 32'd0, "R8");
        apply(4'd8, 32'h0000_5000, 16'h0010, 26'h0, 32'h8000_0001, 32'd0, "R8");
        apply(4'd8, 32'h0000_5000, 16'h0010, 26'h0, 32'd0, 32'd0, "R8");
        // R9: unused codes are quiet
        for (int c = 12; c < 16; c++)
            apply(4'(c), 32'h0000_6000, 16'h0004, 26'h155, 32'd0, 32'd0, "R9");
        // R10: wraparound
        apply(4'd0, 32'hFFFF_FFFC, 16'h0, 26'h0, 32'd0, 32'd0, "R10");
        apply(4'd1, 32'hFFFF_FFF8, 16'h0002, 26'h0, 32'd1, 32'd1, "R10");
        apply(4'd10, 32'hFFFF_FFFC, 16'h0, 26'h000_0001, 32'd0, 32'd0, "R10");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  k;
            logic [31:0] rs;
            logic [31:0] rt;
            k  = 4'($urandom_range(0, 15));
            rs = $urandom;
            case ($urandom_range(0, 5))
                0: rs = 32'd0;
                1: rs = 32'hFFFF_FFFF;
                2: rs = 32'h8000_0000;
                3: rs = 32'h7FFF_FFFF;
                default: ;
            endcase
            rt = ($urandom_range(0, 2) == 0) ? rs : $urandom;
            apply(k, $urandom & 32'hFFFF_FFFC, 16'($urandom), 26'($urandom), rs, rt, tag_of(k));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule